// File: doc/BRIEF.md
# Fractional Product and Accumulator Saturation/Rounding Stage

This block sits behind a 16x16 fractional multiplier and a 40-bit accumulator adder. It receives the raw 32-bit product and the full-precision adder result, which carries one extra bit so that the true sign is never lost. It returns the conditioned values one clock later. On the product path it optionally aligns a signed fractional product with a one-bit left shift. It clamps the single case that alignment cannot represent, and it produces a 16-bit high word that is either truncated or rounded.

On the accumulator path the result is first rounded at bit 16 if rounding is enabled. The rounding is either plain two's-complement or convergent, which is round-half-to-even. The rounded value is then optionally clamped to a 32-bit or a 40-bit signed range. Two overflow flags report whether the rounded value leaves each range, whether or not clamping is switched on, so the flags can feed a condition register.

Control pins take the place of status-register bits: one enables rounding, one picks the rounding kind, one enables saturation, and one picks the saturation width.

Top module: `fxp_satround`

## Requirements
- R1: All outputs are registered and show the result of the inputs sampled at the previous rising clock edge. While rst_n is low, every output is zero.
- R2: With frac_mode=1, prod_q is the raw product shifted left by one bit, with zero entering bit 0. With frac_mode=0, prod_q equals prod_in.
- R3: With frac_mode=1 and prod_in bits 31 and 30 unequal, the shift would overflow. prod_q is then 0x7FFFFFFF if bit 31 is 0 and 0x80000000 if it is 1, and prod_ovf_q is 1. In every other case prod_ovf_q is 0. The raw product 0x40000000, which comes from 0x8000 times 0x8000, therefore gives 0x7FFFFFFF.
- R4: prod_hi_q is bits 31..16 of prod_q when rnd_en=0. When rnd_en=1 it is (prod_q + 0x8000) >> 16, taken as signed, saturating at 0x7FFF when the addition passes the positive limit.
- R5: With rnd_en=1 and rnd_conv=0, the accumulator value is the sign-extended acc_in plus 0x8000, with bits 15..0 then cleared.
- R6: With rnd_en=1 and rnd_conv=1, rounding matches R5 except at a tie, where acc_in bits 15..0 equal 0x8000. At a tie the result has bit 16 equal to 0: if bit 16 was already 0, the low bits are just cleared.
- R7: acc_ovf32_q is 1 when the rounded value lies outside [-2^31, 2^31-1]. acc_ovf40_q is 1 when it lies outside [-2^39, 2^39-1]. Both flags are independent of sat_en.
- R8: With sat_en=1 and sat_sel32=1, an acc_ovf32 condition sets acc_q to 0x007FFFFFFF for a positive true value and to 0xFF80000000 for a negative one.
- R9: With sat_en=1 and sat_sel32=0, an acc_ovf40 condition sets acc_q to 0x7FFFFFFFFF for a positive true value and to 0x8000000000 for a negative one.
- R10: When no clamp applies, including every case with sat_en=0, acc_q is bits 39..0 of the rounded value. An overflowing result wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frac_mode | input | 1 | 1: signed fractional product, aligned by a left shift |
| prod_in | input | 32 | Raw multiplier product |
| acc_in | input | 41 | Adder result, 40 bits plus a true-sign bit |
| rnd_en | input | 1 | Enables rounding on both paths |
| rnd_conv | input | 1 | 1: convergent accumulator rounding, 0: two's-complement |
| sat_en | input | 1 | Enables accumulator saturation |
| sat_sel32 | input | 1 | 1: clamp at 32-bit limits, 0: clamp at 40-bit limits |
| prod_q | output | 32 | Aligned and clamped product |
| prod_hi_q | output | 16 | Truncated or rounded high word of the product |
| prod_ovf_q | output | 1 | Product corner clamp occurred |
| acc_q | output | 40 | Rounded and saturated accumulator value |
| acc_ovf32_q | output | 1 | Rounded value outside the 32-bit signed range |
| acc_ovf40_q | output | 1 | Rounded value outside the 40-bit signed range |

## Verification
The bench aims at the boundaries of each range: values one step inside and one step outside the 32-bit and 40-bit limits, and adder results whose true sign disagrees with bit 39. A design that tests bit 39 instead of the true sign clamps a wrapped result to the wrong extreme. The rounding ties are probed with bit 16 at 0 and at 1. A convergent rounder that ignores parity reproduces the two's-complement result, and one that rounds every tie down is wrong for odd upper bits. The product sweeps include 0x40000000 and the near-maximum products whose rounded high word would wrap to 0x8000 without the clamp.

// File: rtl/fxp_pkg.sv
package fxp_pkg;
    localparam int unsigned DEF_OPW  = 16;
    localparam int unsigned DEF_ACCW = 40;

    typedef enum logic {
        LIM_WIDE   = 1'b0,
        LIM_NARROW = 1'b1
    } lim_sel_e;

    typedef enum logic {
        RND_TWOS = 1'b0,
        RND_CONV = 1'b1
    } rnd_kind_e;
endpackage

// File: rtl/fxp_prod_unit.sv
module fxp_prod_unit #(
    parameter int unsigned OPW = fxp_pkg::DEF_OPW
) (
    input  logic               frac_mode,
    input  logic               rnd_en,
    input  logic [2*OPW-1:0]   raw,
    output logic [2*OPW-1:0]   prod,
    output logic [OPW-1:0]     hi,
    output logic               clamped
);
    localparam int unsigned PRW = 2 * OPW;

    logic [PRW-1:0] shifted;
    logic [OPW:0]   sum;
    logic [OPW-1:0] hi_max;

    always_comb begin
        shifted = frac_mode ? {raw[PRW-2:0], 1'b0} : raw;
        clamped = frac_mode & (raw[PRW-1] ^ raw[PRW-2]);
        if (clamped) begin
            prod = raw[PRW-1] ? {1'b1, {(PRW-1){1'b0}}} : {1'b0, {(PRW-1){1'b1}}};
        end else begin
            prod = shifted;
        end
        hi_max = {1'b0, {(OPW-1){1'b1}}};
        sum    = {prod[PRW-1], prod[PRW-1:OPW]} + {{OPW{1'b0}}, prod[OPW-1]};
        if (!rnd_en) begin
            hi = prod[PRW-1:OPW];
        end else if (sum[OPW] != sum[OPW-1]) begin
            hi = hi_max;
        end else begin
            hi = sum[OPW-1:0];
        end
    end
endmodule

// File: rtl/fxp_acc_round.sv
module fxp_acc_round #(
    parameter int unsigned OPW  = fxp_pkg::DEF_OPW,
    parameter int unsigned ACCW = fxp_pkg::DEF_ACCW
) (
    input  logic              rnd_en,
    input  fxp_pkg::rnd_kind_e kind,
    input  logic [ACCW:0]     a,
    output logic [ACCW+1:0]   r
);
    localparam int unsigned EXTW = ACCW + 2;

    logic [EXTW-1:0] ext;
    logic [EXTW-1:0] half;
    logic [EXTW-1:0] sum;
    logic            tie;
    logic            keep_even;

    always_comb begin
        ext       = {a[ACCW], a};
        half      = EXTW'(1) << (OPW - 1);
        tie       = (a[OPW-1:0] == half[OPW-1:0]);
        keep_even = (kind == fxp_pkg::RND_CONV) & tie & ~a[OPW];
        sum       = ext + (keep_even ? '0 : half);
        r         = rnd_en ? {sum[EXTW-1:OPW], {OPW{1'b0}}} : ext;
    end
endmodule

// File: rtl/fxp_acc_sat.sv
module fxp_acc_sat #(
    parameter int unsigned OPW  = fxp_pkg::DEF_OPW,
    parameter int unsigned ACCW = fxp_pkg::DEF_ACCW
) (
    input  logic               sat_en,
    input  fxp_pkg::lim_sel_e  sel,
    input  logic [ACCW+1:0]    r,
    output logic [ACCW-1:0]    y,
    output logic               ovf_n,
    output logic               ovf_w
);
    localparam int unsigned EXTW = ACCW + 2;
    localparam int unsigned LW   = 2 * OPW;
    localparam int unsigned TOPW = EXTW - ACCW + 1;
    localparam int unsigned TOPN = EXTW - LW + 1;

    logic            neg;
    logic [ACCW-1:0] max_n, min_n, max_w, min_w;

    always_comb begin
        neg   = r[EXTW-1];
        ovf_w = (r[EXTW-1:ACCW-1] != {TOPW{neg}});
        ovf_n = (r[EXTW-1:LW-1]   != {TOPN{neg}});
        max_n = {{(ACCW-LW+1){1'b0}}, {(LW-1){1'b1}}};
        min_n = {{(ACCW-LW+1){1'b1}}, {(LW-1){1'b0}}};
        max_w = {1'b0, {(ACCW-1){1'b1}}};
        min_w = {1'b1, {(ACCW-1){1'b0}}};
        y     = r[ACCW-1:0];
        if (sat_en) begin
            if (sel == fxp_pkg::LIM_NARROW) begin
                if (ovf_n) y = neg ? min_n : max_n;
            end else begin
                if (ovf_w) y = neg ? min_w : max_w;
            end
        end
    end
endmodule

// File: rtl/fxp_satround.sv
module fxp_satround #(
    parameter int unsigned OPW  = fxp_pkg::DEF_OPW,
    parameter int unsigned ACCW = fxp_pkg::DEF_ACCW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frac_mode,
    input  logic [2*OPW-1:0]  prod_in,
    input  logic [ACCW:0]     acc_in,
    input  logic              rnd_en,
    input  logic              rnd_conv,
    input  logic              sat_en,
    input  logic              sat_sel32,
    output logic [2*OPW-1:0]  prod_q,
    output logic [OPW-1:0]    prod_hi_q,
    output logic              prod_ovf_q,
    output logic [ACCW-1:0]   acc_q,
    output logic              acc_ovf32_q,
    output logic              acc_ovf40_q
);
    localparam int unsigned PRW  = 2 * OPW;
    localparam int unsigned EXTW = ACCW + 2;
    localparam int unsigned LW   = 2 * OPW;

    typedef struct packed {
        logic [PRW-1:0]  prod;
        logic [OPW-1:0]  hi;
        logic            povf;
        logic [ACCW-1:0] acc;
        logic            ovf_n;
        logic            ovf_w;
    } out_t;

    out_t st_d, st_q;

    logic [PRW-1:0]  prod_w;
    logic [OPW-1:0]  hi_w;
    logic            povf_w;
    logic [EXTW-1:0] rnd_w;
    logic [ACCW-1:0] acc_w;
    logic            ovfn_w, ovfw_w;

    fxp_prod_unit #(.OPW(OPW)) u_prod (
        .frac_mode (frac_mode),
        .rnd_en    (rnd_en),
        .raw       (prod_in),
        .prod      (prod_w),
        .hi        (hi_w),
        .clamped   (povf_w)
    );

    fxp_acc_round #(.OPW(OPW), .ACCW(ACCW)) u_round (
        .rnd_en (rnd_en),
        .kind   (rnd_conv ? fxp_pkg::RND_CONV : fxp_pkg::RND_TWOS),
        .a      (acc_in),
        .r      (rnd_w)
    );

    fxp_acc_sat #(.OPW(OPW), .ACCW(ACCW)) u_sat (
        .sat_en (sat_en),
        .sel    (sat_sel32 ? fxp_pkg::LIM_NARROW : fxp_pkg::LIM_WIDE),
        .r      (rnd_w),
        .y      (acc_w),
        .ovf_n  (ovfn_w),
        .ovf_w  (ovfw_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.prod  = prod_w;
        st_d.hi    = hi_w;
        st_d.povf  = povf_w;
        st_d.acc   = acc_w;
        st_d.ovf_n = ovfn_w;
        st_d.ovf_w = ovfw_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prod_q      = st_q.prod;
    assign prod_hi_q   = st_q.hi;
    assign prod_ovf_q  = st_q.povf;
    assign acc_q       = st_q.acc;
    assign acc_ovf32_q = st_q.ovf_n;
    assign acc_ovf40_q = st_q.ovf_w;

    AST_PROD_CORNER: assert property (@(posedge clk) disable iff (!rst_n)
        (frac_mode && !prod_in[PRW-1] && prod_in[PRW-2])
        |=> (prod_q == {1'b0, {(PRW-1){1'b1}}}) && prod_ovf_q); // R3

    AST_FLAG_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ovf40_q |-> acc_ovf32_q); // R7

    AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_en && sat_sel32)
        |=> (acc_q[ACCW-1:LW-1] == {(ACCW-LW+1){acc_q[ACCW-1]}})); // R8

    AST_WIDE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_en && !sat_sel32 && !rnd_en)
        |=> (acc_q[ACCW-1] == $past(acc_in[ACCW]))); // R9

    AST_RND_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_en && !sat_en) |=> (acc_q[OPW-1:0] == '0)); // R5

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!rnd_en && !sat_en) |=> (acc_q == $past(acc_in[ACCW-1:0]))); // R10
endmodule

// File: tb/fxp_satround_test.sv
module fxp_satround_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frac_mode = 1'b0;
    logic [31:0] prod_in = '0;
    logic [40:0] acc_in = '0;
    logic        rnd_en = 1'b0, rnd_conv = 1'b0, sat_en = 1'b0, sat_sel32 = 1'b0;
    logic [31:0] prod_q;
    logic [15:0] prod_hi_q;
    logic        prod_ovf_q;
    logic [39:0] acc_q;
    logic        acc_ovf32_q, acc_ovf40_q;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fxp_satround uut (
        .clk(clk), .rst_n(rst_n), .frac_mode(frac_mode), .prod_in(prod_in),
        .acc_in(acc_in), .rnd_en(rnd_en), .rnd_conv(rnd_conv), .sat_en(sat_en),
        .sat_sel32(sat_sel32), .prod_q(prod_q), .prod_hi_q(prod_hi_q),
        .prod_ovf_q(prod_ovf_q), .acc_q(acc_q), .acc_ovf32_q(acc_ovf32_q),
        .acc_ovf40_q(acc_ovf40_q)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic fm, input logic [31:0] p, input logic [40:0] a,
                         input logic re, input logic rc, input logic se, input logic s32);
        logic [31:0] ep;
        logic [15:0] eh;
        logic        eo, o32, o40, tie;
        longint      ps, av, rv;
        logic [63:0] ea;
        string       tag;
        @(negedge clk);
        frac_mode = fm; prod_in = p; acc_in = a;
        rnd_en = re; rnd_conv = rc; sat_en = se; sat_sel32 = s32;
        eo = fm && (p[31] != p[30]);
        if (eo) ep = p[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
        else    ep = fm ? {p[30:0], 1'b0} : p;
        if (!re) eh = ep[31:16];
        else if (ep[31:16] == 16'h7FFF && ep[15]) eh = 16'h7FFF;
        else begin
            ps = longint'($signed(ep));
            ps = (ps + 32768) >>> 16;
            eh = ps[15:0];
        end
        av  = longint'($signed(a));
        tie = (a[15:0] == 16'h8000);
        if (!re) rv = av;
        else if (rc && tie && !a[16]) rv = av & ~64'hFFFF;
        else rv = (av + 32768) & ~64'hFFFF;
        o32 = (rv > 64'sh7FFF_FFFF) || (rv < -64'sh8000_0000);
        o40 = (rv > 64'sh7F_FFFF_FFFF) || (rv < -64'sh80_0000_0000);
        ea = 64'(rv) & 64'hFF_FFFF_FFFF;
        tag = !re ? "R10" : ((rc && tie) ? "R6" : "R5");
        if (se && s32 && o32) begin
            ea = (rv < 0) ? 64'hFF_8000_0000 : 64'h00_7FFF_FFFF; tag = "R8";
        end else if (se && !s32 && o40) begin
            ea = (rv < 0) ? 64'h80_0000_0000 : 64'h7F_FFFF_FFFF; tag = "R9";
        end
        @(posedge clk);
        @(negedge clk);
        check(eo ? "R3" : "R2", 64'(prod_q), 64'(ep));
        check("R3 flag", 64'(prod_ovf_q), 64'(eo));
        check("R4", 64'(prod_hi_q), 64'(eh));
        check(tag, 64'(acc_q), ea);
        check("R7 ovf32", 64'(acc_ovf32_q), 64'(o32));
        check("R7 ovf40", 64'(acc_ovf40_q), 64'(o40));
    endtask

    logic [31:0] plist [12] = '{32'h4000_0000, 32'hC000_0000, 32'h3FFF_FFFF, 32'hBFFF_FFFF,
                                32'h0000_0000, 32'hFFFF_FFFF, 32'h3FFF_C000, 32'h7FFF_8000,
                                32'h7FFF_7FFF, 32'h8000_0000, 32'h0000_4000, 32'h1234_C000};
    logic [40:0] alist [16] = '{41'h000_7FFF_FFFF, 41'h000_8000_0000, 41'h1FF_8000_0000,
                                41'h1FF_7FFF_FFFF, 41'h07F_FFFF_FFFF, 41'h080_0000_0000,
                                41'h180_0000_0000, 41'h17F_FFFF_FFFF, 41'h000_7FFF_8000,
                                41'h000_0001_8000, 41'h000_0002_8000, 41'h1FF_FFFF_8000,
                                41'h07F_FFFF_8000, 41'h0FF_FFFF_FFFF, 41'h100_0000_0000,
                                41'h000_0000_0000};

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset prod", 64'(prod_q), 64'd0);
        check("R1 reset acc", 64'(acc_q), 64'd0);
        check("R1 reset flags", 64'({prod_hi_q, prod_ovf_q, acc_ovf32_q, acc_ovf40_q}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle", 64'(acc_q), 64'd0);
        for (int i = 0; i < 12; i++)
            for (int c = 0; c < 4; c++)
                apply(c[0], plist[i], 41'd0, c[1], 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++)
            for (int c = 0; c < 16; c++)
                apply(1'b0, 32'd0, alist[i], c[0], c[1], c[2], c[3]);
        for (int k = 0; k < 3000; k++) begin
            logic [40:0] a;
            logic [31:0] p;
            logic [3:0]  cf;
            a  = alist[$urandom_range(15)] + 41'($signed(16'($urandom)));
            p  = plist[$urandom_range(11)] ^ 32'($urandom_range(3));
            cf = 4'($urandom);
            apply(k[0], p, a, cf[0], cf[1], cf[2], cf[3]);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        done = 1;
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule